// File: doc/BRIEF.md
# Multi-Mode Operand Address Unit

This unit executes one two-operand add at a time. The destination register receives its own value plus a source operand. The source operand comes from a second register, from a constant field, or from data memory. When it comes from memory, the address is formed under one of several addressing modes. The caller presents a decoded mode code, three register indices, a signed constant field, an absolute address field and a 2-bit operand size, and pulses `start`. The unit reads its small internal register file and issues zero, one or two dependent reads on a synchronous data-memory port. In the auto-increment and auto-decrement modes it also writes back the changed base register. It finishes with a one-cycle `done` pulse, which carries the sum written to the destination.

The operand size selects a byte count d of 1, 2, 4 or 8. That count is the step of the auto-modify modes and the scale factor of the index register. Register 0 is hard-wired to zero. A register value can be observed by issuing a register-mode add of that register with register 0, which returns the register unchanged on `res_data`.

Top module: `opaddr_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `done`, `busy` and `mem_re` are low.
- R2: Mode code 0 (register) writes Rd+Rb to Rd, makes no memory read, and pulses `done` in the 2nd cycle after the cycle in which `start` was accepted.
- R3: Mode code 1 (immediate) writes Rd plus the sign-extended constant field to Rd, with no memory read and the same latency as R2.
- R4: Mode code 2 (displacement) makes one read at Rb plus the sign-extended constant and writes Rd plus the read word. Every single-read mode pulses `done` in the 3rd cycle after acceptance, and read data is valid the cycle after `mem_re`.
- R5: Mode code 3 (register-indirect) reads at Rb, and mode code 4 (indexed) reads at Rb+Rx, one read each.
- R6: Mode code 5 (direct) reads at the absolute address field, ignoring all register values for the address.
- R7: Mode code 6 (memory-indirect) reads at Rb, then reads at the low address bits of the returned word, and adds the second word. `done` pulses in the 4th cycle after acceptance.
- R8: Mode code 7 (auto-increment) reads at Rb, and afterwards Rb becomes Rb+d, where d = 1, 2, 4, 8 for size codes 0 to 3.
- R9: Mode code 8 (auto-decrement) first sets Rb to Rb-d, and then reads at that new value.
- R10: Mode code 9 (scaled) reads at the sign-extended constant + Rb + Rx*d.
- R11: Register 0 always reads as zero, and any write aimed at it is dropped.
- R12: The sum is Rd as it stood when `start` was accepted plus the operand, and it is written last. When Rd equals the auto-modified Rb, Rd ends holding the sum.
- R13: Mode codes 10 to 15 change no register, make no read, and pulse `done` with the latency of R2. A `start` while `busy` is ignored, and `done` lasts exactly one cycle.
- R14: All addresses are the low ADDR_W bits of their sums, so they wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept an instruction when idle |
| mode | input | 4 | Addressing mode code |
| rd_sel | input | IDX_W | Destination register index |
| rb_sel | input | IDX_W | Base / second register index |
| rx_sel | input | IDX_W | Index register index |
| disp | input | DISP_W | Signed constant (displacement or immediate) |
| abs_addr | input | ADDR_W | Absolute address for direct mode |
| size | input | 2 | Operand size code, d = 1 << size |
| mem_re | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_re` |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| res_data | output | DATA_W | Sum written to the destination, valid with `done` |

## Verification
Several cases are hard to reach from the ports. One is a memory-indirect read whose second address depends on returned data. Another is an auto-modify add whose destination is also its base, where two writes to one register race. A third is a register-0 base absorbing an update. The bench memory returns a word computed from its address, so each pointer is predictable yet different per address. Random instructions draw all register indices from a small pool, so destination/base collisions and register-0 operands happen often. Directed cases force the colliding auto-modes at every size, a second `start` during a busy instruction, and unused mode codes. Register contents are then read back through register-mode adds with register 0.

// File: rtl/opaddr_pkg.sv
// Package: shared mode codes and controller states for the operand address unit.
// Assumes a 4-bit mode code; codes above MD_SCALED are unused.
package opaddr_pkg;
    typedef enum logic [3:0] {
        MD_REG     = 4'd0,
        MD_IMM     = 4'd1,
        MD_DISP    = 4'd2,
        MD_RIND    = 4'd3,
        MD_INDEX   = 4'd4,
        MD_DIRECT  = 4'd5,
        MD_MIND    = 4'd6,
        MD_AUTOINC = 4'd7,
        MD_AUTODEC = 4'd8,
        MD_SCALED  = 4'd9
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_EXEC  = 3'd1,
        ST_WAIT1 = 3'd2,
        ST_WAIT2 = 3'd3,
        ST_WB    = 3'd4
    } state_e;
endpackage

// File: rtl/opaddr_regfile.sv
// Module: general register file with one write port and NRD read ports.
// Register 0 reads as zero and ignores writes. Reads are combinational.
module opaddr_regfile #(
    parameter int DATA_W = 32,
    parameter int NREG   = 8,
    parameter int NRD    = 3,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr [NRD],
    output logic [DATA_W-1:0] rdata [NRD]
);
    logic [DATA_W-1:0] regs [NREG];

    // Storage update: clear on reset, write any register except register 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    // One combinational read path per port, zero forced for index 0.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
    end

    // A write to a nonzero register is visible on the next cycle.
    p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata));

    // Register 0 storage never takes a nonzero value.
    p_zero_reg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs[0] == '0);
endmodule

// File: rtl/opaddr_agen.sv
// Module: combinational address generator. It decodes the latched mode into
// the first read address, the non-memory operand, the auto-modified base value
// and the sequencing flags. Addresses wrap to ADDR_W bits.
module opaddr_agen
    import opaddr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int DISP_W = 12
) (
    input  logic [3:0]        mode,
    input  logic [DATA_W-1:0] base_v,
    input  logic [DATA_W-1:0] idx_v,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] abs_addr,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] direct_op,
    output logic [DATA_W-1:0] base_next,
    output logic              use_mem,
    output logic              two_rd,
    output logic              pre_upd,
    output logic              post_upd,
    output logic              legal
);
    logic [DATA_W-1:0] disp_s;
    logic [DATA_W-1:0] step;
    logic [DATA_W-1:0] sum_a;

    assign disp_s = {{(DATA_W-DISP_W){disp[DISP_W-1]}}, disp};
    assign step   = DATA_W'(1) << size;

    // Mode decode: effective address sum and sequencing flags.
    always_comb begin
        sum_a     = '0;
        direct_op = '0;
        base_next = base_v;
        use_mem   = 1'b1;
        two_rd    = 1'b0;
        pre_upd   = 1'b0;
        post_upd  = 1'b0;
        legal     = 1'b1;
        case (mode)
            MD_REG:     begin use_mem = 1'b0; direct_op = base_v; end
            MD_IMM:     begin use_mem = 1'b0; direct_op = disp_s; end
            MD_DISP:    sum_a = base_v + disp_s;
            MD_RIND:    sum_a = base_v;
            MD_INDEX:   sum_a = base_v + idx_v;
            MD_DIRECT:  sum_a = DATA_W'(abs_addr);
            MD_MIND:    begin sum_a = base_v; two_rd = 1'b1; end
            MD_AUTOINC: begin
                sum_a     = base_v;
                base_next = base_v + step;
                post_upd  = 1'b1;
            end
            MD_AUTODEC: begin
                base_next = base_v - step;
                sum_a     = base_v - step;
                pre_upd   = 1'b1;
            end
            MD_SCALED:  sum_a = disp_s + base_v + (idx_v << size);
            default:    begin use_mem = 1'b0; legal = 1'b0; end
        endcase
    end

    assign addr = sum_a[ADDR_W-1:0];
endmodule

// File: rtl/opaddr_ctrl.sv
// Module: instruction sequencer. It latches the instruction and its register
// values on acceptance, issues up to two dependent reads, performs the base
// update before (auto-decrement) or after (auto-increment) the read, and
// writes the sum last. Assumes one-cycle memory read latency.
module opaddr_ctrl
    import opaddr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int DISP_W = 12,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode_in,
    input  logic [IDX_W-1:0]  rd_in,
    input  logic [IDX_W-1:0]  rb_in,
    input  logic [DISP_W-1:0] disp_in,
    input  logic [ADDR_W-1:0] abs_in,
    input  logic [1:0]        size_in,
    input  logic [DATA_W-1:0] rd_val,
    input  logic [DATA_W-1:0] rb_val,
    input  logic [DATA_W-1:0] rx_val,
    input  logic [ADDR_W-1:0] ag_addr,
    input  logic [DATA_W-1:0] ag_direct,
    input  logic [DATA_W-1:0] ag_base_next,
    input  logic              ag_use_mem,
    input  logic              ag_two_rd,
    input  logic              ag_pre,
    input  logic              ag_post,
    input  logic              ag_legal,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [3:0]        l_mode,
    output logic [DATA_W-1:0] l_base,
    output logic [DATA_W-1:0] l_idx,
    output logic [DISP_W-1:0] l_disp,
    output logic [ADDR_W-1:0] l_abs,
    output logic [1:0]        l_size,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] res_data
);
    state_e            state;
    logic [IDX_W-1:0]  l_rd;
    logic [IDX_W-1:0]  l_rb;
    logic [DATA_W-1:0] l_dst;
    logic [DATA_W-1:0] opnd;

    // State sequencing and capture of instruction fields and operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            l_mode <= '0;
            l_rd   <= '0;
            l_rb   <= '0;
            l_base <= '0;
            l_idx  <= '0;
            l_dst  <= '0;
            l_disp <= '0;
            l_abs  <= '0;
            l_size <= '0;
            opnd   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    l_mode <= mode_in;
                    l_rd   <= rd_in;
                    l_rb   <= rb_in;
                    l_dst  <= rd_val;
                    l_base <= rb_val;
                    l_idx  <= rx_val;
                    l_disp <= disp_in;
                    l_abs  <= abs_in;
                    l_size <= size_in;
                    state  <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (ag_use_mem) begin
                        state <= ST_WAIT1;
                    end else begin
                        opnd  <= ag_direct;
                        state <= ST_WB;
                    end
                end
                ST_WAIT1: begin
                    if (ag_two_rd) begin
                        state <= ST_WAIT2;
                    end else begin
                        opnd  <= mem_rdata;
                        state <= ST_WB;
                    end
                end
                ST_WAIT2: begin
                    opnd  <= mem_rdata;
                    state <= ST_WB;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign res_data = l_dst + opnd;
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_WB);

    // Per-state memory requests and register-file writes.
    always_comb begin
        mem_re   = 1'b0;
        mem_addr = '0;
        wr_en    = 1'b0;
        wr_idx   = '0;
        wr_data  = '0;
        case (state)
            ST_EXEC: begin
                mem_re   = ag_use_mem;
                mem_addr = ag_addr;
                if (ag_pre) begin
                    wr_en   = 1'b1;
                    wr_idx  = l_rb;
                    wr_data = ag_base_next;
                end
            end
            ST_WAIT1: begin
                if (ag_two_rd) begin
                    mem_re   = 1'b1;
                    mem_addr = mem_rdata[ADDR_W-1:0];
                end else if (ag_post) begin
                    wr_en   = 1'b1;
                    wr_idx  = l_rb;
                    wr_data = ag_base_next;
                end
            end
            ST_WB: begin
                wr_en   = ag_legal;
                wr_idx  = l_rd;
                wr_data = res_data;
            end
            default: ;
        endcase
    end

    // Completion is a single-cycle pulse.
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A read is always followed by a wait state, never by completion (R4 latency).
    p_read_then_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !done);

    // Work begins only in response to a start request.
    p_accept_on_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // The second wait state of memory-indirect follows a read issued the cycle before.
    p_second_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT2) |-> $past(mem_re));
endmodule

// File: rtl/opaddr_unit.sv
// Module: top of the multi-mode operand address unit. It wires the register
// file, the sequencer and the address generator. The register file is read
// with the incoming indices, and the sequencer latches those values on accept.
module opaddr_unit #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int DISP_W = 12,
    parameter int NREG   = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [IDX_W-1:0]  rd_sel,
    input  logic [IDX_W-1:0]  rb_sel,
    input  logic [IDX_W-1:0]  rx_sel,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] abs_addr,
    input  logic [1:0]        size,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] res_data
);
    logic [IDX_W-1:0]  rf_raddr [3];
    logic [DATA_W-1:0] rf_rdata [3];
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic [3:0]        l_mode;
    logic [DATA_W-1:0] l_base, l_idx;
    logic [DISP_W-1:0] l_disp;
    logic [ADDR_W-1:0] l_abs;
    logic [1:0]        l_size;
    logic [ADDR_W-1:0] ag_addr;
    logic [DATA_W-1:0] ag_direct, ag_base_next;
    logic              ag_use_mem, ag_two_rd, ag_pre, ag_post, ag_legal;

    assign rf_raddr[0] = rd_sel;
    assign rf_raddr[1] = rb_sel;
    assign rf_raddr[2] = rx_sel;

    opaddr_regfile #(.DATA_W(DATA_W), .NREG(NREG), .NRD(3)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_idx), .wdata(wr_data),
        .raddr(rf_raddr), .rdata(rf_rdata)
    );

    opaddr_agen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
        .mode(l_mode), .base_v(l_base), .idx_v(l_idx), .disp(l_disp),
        .abs_addr(l_abs), .size(l_size), .addr(ag_addr), .direct_op(ag_direct),
        .base_next(ag_base_next), .use_mem(ag_use_mem), .two_rd(ag_two_rd),
        .pre_upd(ag_pre), .post_upd(ag_post), .legal(ag_legal)
    );

    opaddr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode),
        .rd_in(rd_sel), .rb_in(rb_sel), .disp_in(disp), .abs_in(abs_addr),
        .size_in(size), .rd_val(rf_rdata[0]), .rb_val(rf_rdata[1]),
        .rx_val(rf_rdata[2]), .ag_addr(ag_addr), .ag_direct(ag_direct),
        .ag_base_next(ag_base_next), .ag_use_mem(ag_use_mem),
        .ag_two_rd(ag_two_rd), .ag_pre(ag_pre), .ag_post(ag_post),
        .ag_legal(ag_legal), .mem_rdata(mem_rdata), .l_mode(l_mode),
        .l_base(l_base), .l_idx(l_idx), .l_disp(l_disp), .l_abs(l_abs),
        .l_size(l_size), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .mem_re(mem_re), .mem_addr(mem_addr), .busy(busy), .done(done),
        .res_data(res_data)
    );

    // Unused mode codes never touch the register file at completion.
    p_unused_no_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (done && l_mode > 4'd9) |-> !wr_en);

    // No memory traffic while idle.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_re);
endmodule

// File: tb/tb_opaddr_unit.sv
// Bench: fixed-seed random instructions mixed with directed cases, against a
// shadow register model and a computed memory image.
module tb_opaddr_unit;
    localparam int DW = 32, AW = 16, DSW = 12, NR = 8;

    logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [3:0]    mode = '0;
    logic [2:0]    rd_sel = '0, rb_sel = '0, rx_sel = '0;
    logic [DSW-1:0] disp = '0;
    logic [AW-1:0] abs_addr = '0;
    logic [1:0]    size = '0;
    logic          mem_re, busy, done;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0, res_data;

    int errors = 0, checks = 0, nrd = 0;
    logic [AW-1:0] rd_log [4];
    logic [DW-1:0] model [NR];

    opaddr_unit dut (.*);

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction

    // Memory model: one-cycle read latency.
    always @(posedge clk) if (mem_re) mem_rdata <= memf(mem_addr);

    // Read address log, sampled away from the clock edge.
    always @(negedge clk) begin
        if (mem_re) begin
            if (nrd < 4) rd_log[nrd] = mem_addr;
            nrd++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'd0: return "R2"; 4'd1: return "R3"; 4'd2: return "R4";
            4'd3, 4'd4: return "R5"; 4'd5: return "R6"; 4'd6: return "R7";
            4'd7: return "R8"; 4'd8: return "R9"; 4'd9: return "R10";
            default: return "R13";
        endcase
    endfunction

    task automatic run_op(input logic [3:0] m, input logic [2:0] d, input logic [2:0] b,
                          input logic [2:0] x, input logic [DSW-1:0] c,
                          input logic [AW-1:0] ab, input logic [1:0] sz, input bit glitch);
        logic [DW-1:0] ds, stp, bv, xv, opv, exp_res, sum_a;
        logic [AW-1:0] ea [2];
        int en, elat, lat;
        string tg;
        tg   = tag_of(m);
        ds   = {{(DW-DSW){c[DSW-1]}}, c};
        stp  = DW'(1) << sz;
        bv   = model[b];
        xv   = model[x];
        en   = 1; elat = 3; opv = '0; sum_a = '0;
        case (m)
            4'd0: begin en = 0; elat = 2; opv = bv; end
            4'd1: begin en = 0; elat = 2; opv = ds; end
            4'd2: sum_a = bv + ds;
            4'd3: sum_a = bv;
            4'd4: sum_a = bv + xv;
            4'd5: sum_a = DW'(ab);
            4'd6: begin sum_a = bv; en = 2; elat = 4; end
            4'd7: sum_a = bv;
            4'd8: sum_a = bv - stp;
            4'd9: sum_a = ds + bv + (xv << sz);
            default: begin en = 0; elat = 2; end
        endcase
        ea[0] = sum_a[AW-1:0];
        ea[1] = memf(ea[0]) ;
        ea[1] = ~ea[0];
        if (en == 1) opv = memf(ea[0]);
        if (en == 2) opv = memf(ea[1]);
        exp_res = model[d] + opv;
        // Drive the instruction for one cycle.
        @(negedge clk);
        nrd = 0;
        mode = m; rd_sel = d; rb_sel = b; rx_sel = x; disp = c; abs_addr = ab; size = sz;
        start = 1'b1;
        @(negedge clk);
        lat = 1;
        if (glitch) begin
            mode = 4'd1; rd_sel = 3'd1; rb_sel = 3'd0; disp = 12'd77;
        end else start = 1'b0;
        while (!done && lat < 20) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        chk(done == 1'b1, {tg, " done seen"}, DW'(done), 1);
        chk(lat == elat, {tg, " latency"}, DW'(lat), DW'(elat));
        chk(nrd == en, {tg, " read count"}, DW'(nrd), DW'(en));
        if (en >= 1) chk(rd_log[0] == ea[0], {tg, " R14 first address"}, DW'(rd_log[0]), DW'(ea[0]));
        if (en == 2) chk(rd_log[1] == ea[1], {tg, " second address"}, DW'(rd_log[1]), DW'(ea[1]));
        if (m <= 4'd9) chk(res_data == exp_res, {tg, " sum"}, res_data, exp_res);
        // Shadow model: base update first, destination last (R12), register 0 fixed (R11).
        if (m == 4'd7) model[b] = bv + stp;
        if (m == 4'd8) model[b] = bv - stp;
        if (m <= 4'd9) model[d] = exp_res;
        model[0] = '0;
    endtask

    task automatic read_all(input string why);
        for (int k = 0; k < NR; k++) begin
            logic [DW-1:0] e;
            e = model[k];
            run_op(4'd0, 3'(k), 3'd0, 3'd0, '0, '0, 2'd0, 1'b0);
            chk(res_data == e, {why, " readback"}, res_data, e);
        end
    endtask

    initial begin
        int wd;
        wd = 0;
        while (wd < 150000) begin @(posedge clk); wd++; end
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", wd);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NR; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy && !mem_re, "R1 idle outputs", DW'({done, busy, mem_re}), 0);
        read_all("R1");
        // R11: a write aimed at register 0 is dropped.
        run_op(4'd1, 3'd0, 3'd0, 3'd0, 12'd100, '0, 2'd0, 1'b0);
        read_all("R11");
        // Seed registers through immediate adds (R3), one negative.
        for (int k = 1; k < NR; k++)
            run_op(4'd1, 3'(k), 3'd0, 3'd0, DSW'(k * 40 + 3), '0, 2'd0, 1'b0);
        run_op(4'd1, 3'd5, 3'd0, 3'd0, 12'hF00, '0, 2'd0, 1'b0);
        read_all("R3");
        // R7 memory-indirect and R6 direct at the top of the address space (R14).
        run_op(4'd6, 3'd2, 3'd3, 3'd0, '0, '0, 2'd0, 1'b0);
        run_op(4'd5, 3'd4, 3'd0, 3'd0, '0, 16'hFFFF, 2'd0, 1'b0);
        // R12: destination equals the auto-modified base at every size.
        for (int s = 0; s < 4; s++) begin
            run_op(4'd7, 3'd6, 3'd6, 3'd0, '0, '0, 2'(s), 1'b0);
            run_op(4'd8, 3'd7, 3'd7, 3'd0, '0, '0, 2'(s), 1'b0);
            run_op(4'd7, 3'd1, 3'd3, 3'd0, '0, '0, 2'(s), 1'b0);
            run_op(4'd8, 3'd2, 3'd4, 3'd0, '0, '0, 2'(s), 1'b0);
        end
        read_all("R12 R8 R9");
        // R10 scaled with negative constant, R13 start while busy and unused modes.
        run_op(4'd9, 3'd1, 3'd2, 3'd3, 12'h800, '0, 2'd3, 1'b0);
        run_op(4'd2, 3'd3, 3'd4, 3'd0, 12'd5, '0, 2'd0, 1'b1);
        run_op(4'd6, 3'd5, 3'd6, 3'd0, '0, '0, 2'd0, 1'b1);
        run_op(4'd12, 3'd1, 3'd2, 3'd3, 12'd9, 16'h10, 2'd1, 1'b0);
        run_op(4'd15, 3'd7, 3'd7, 3'd7, 12'd9, 16'h10, 2'd1, 1'b0);
        read_all("R13");
        // Random mix.
        for (int n = 0; n < 600; n++) begin
            logic [3:0] m;
            m = ($urandom % 16 == 0) ? 4'(10 + $urandom % 6) : 4'($urandom % 10);
            run_op(m, 3'($urandom), 3'($urandom), 3'($urandom), DSW'($urandom),
                   AW'($urandom), 2'($urandom), ($urandom % 8) == 0);
            if (n % 100 == 99) read_all("R2 random");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule